// File: doc/BRIEF.md
# GPIO Register Front End with Magic-Word Lock

This block is the register file for a 32-pin general-purpose I/O controller. It takes simple 32-bit word accesses (valid, write, address, write data) and returns read data one cycle later. It holds the configuration words: polarity, data out, output enable, open-drain select, pull-up, pull-down, input enable, event type, both-edge select, event enable, slew rate and drive strength. These words drive the pin-resolution and event blocks that sit beside it.

A write lock protects the configuration. Any write to either lock word engages the lock. Once engaged, only the lock words accept writes. The lock is released by first writing a key to the second lock word and then writing a different key to the first lock word. Data out, output enable and event enable each have write-only set and clear alias words that change only the bits written as one. Accesses to unmapped or misaligned addresses, and writes dropped by the lock, raise a one-cycle error pulse.

Top module: `gpio_lock_regs`

## Requirements
- R1: After reset every stored word reads zero and the block is unlocked. The exceptions are pull-up (0x18), pull-down (0x1C), slew (0x38) and drive (0x3C), which hold the parameters PU_RST, PD_RST, SLEW_RST and DRIVE_RST.
- R2: While unlocked, a write of any value to lock word A (0x00) or lock word B (0x7C) engages the lock. Lock word A then reads 1, and the block counts as locked exactly while lock word A holds 1.
- R3: While locked, a write to any mapped word other than the two lock words leaves every stored word unchanged and raises the error pulse.
- R4: While locked, a write to lock word B stores the written value. A write of 0xC0DEFA73 to lock word A while lock word B holds 0xC0DE1248 clears the lock, and lock word B returns to 0.
- R5: While locked, a write to lock word A with any other value, or while lock word B holds any other value, has no effect and raises no error.
- R6: Alias words act only on the bits written as one. Data-out set is at 0x68 and data-out clear at 0x6C. Output-enable set is at 0x70 and output-enable clear at 0x74. Data out is at 0x0C and output enable at 0x10.
- R7: Lock word B, the four data/output-enable alias words, and the event-enable set (0x30) and clear (0x34) words all read as zero.
- R8: A read of 0x04 returns the pin_in port. A write to 0x04 changes nothing.
- R9: An access to an unmapped or misaligned address reads zero, leaves state unchanged and raises the error pulse.
- R10: Reads are never blocked by the lock.
- R11: Read data and the error pulse appear in the cycle after the request. The error pulse lasts one cycle.
- R12: Event-enable set (0x30) and clear (0x34) change only the written bits of event enable (0x2C).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle error pulse |
| pin_in | input | 32 | Sampled pin levels shown at 0x04 |
| pol_o | output | 32 | Polarity word |
| dout_o | output | 32 | Data-out word |
| oe_o | output | 32 | Output-enable word |
| odrain_o | output | 32 | Open-drain select |
| pull_up_o | output | 32 | Pull-up enables |
| pull_dn_o | output | 32 | Pull-down enables |
| in_en_o | output | 32 | Input enables |
| ev_type_o | output | 32 | Event type select |
| ev_both_o | output | 32 | Both-edge select |
| ev_en_o | output | 32 | Event enables |
| slew_o | output | 32 | Slew-rate select |
| drive_o | output | 32 | Drive-strength select |

## Verification
Data out is driven through overlapping set and clear masks. This shows whether the aliases merge with the stored value or overwrite it. The lock is exercised in several orders: the correct key pair, the right key A with lock word B still zero, a wrong key A with the right key B, and a relock straight after unlock. Together these separate a true two-word check from one that looks at only one word or fails to clear lock word B. Misaligned, out-of-range and write-only addresses are each read and written, to tell apart the zero-read behaviour and the error flag.

// File: rtl/gpio_lock_regs.sv
module gpio_lock_regs #(
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] PU_RST    = 32'h0,
  parameter logic [31:0] PD_RST    = 32'h0,
  parameter logic [31:0] SLEW_RST  = 32'h0,
  parameter logic [31:0] DRIVE_RST = 32'h0,
  parameter logic [31:0] KEY_A     = 32'hC0DEFA73,
  parameter logic [31:0] KEY_B     = 32'hC0DE1248
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pol_o,
  output logic [31:0]       dout_o,
  output logic [31:0]       oe_o,
  output logic [31:0]       odrain_o,
  output logic [31:0]       pull_up_o,
  output logic [31:0]       pull_dn_o,
  output logic [31:0]       in_en_o,
  output logic [31:0]       ev_type_o,
  output logic [31:0]       ev_both_o,
  output logic [31:0]       ev_en_o,
  output logic [31:0]       slew_o,
  output logic [31:0]       drive_o
);
  localparam int WI = ADDR_W - 2;
  localparam logic [WI-1:0] W_LOCKA  = WI'('h00 >> 2);
  localparam logic [WI-1:0] W_PIN    = WI'('h04 >> 2);
  localparam logic [WI-1:0] W_POL    = WI'('h08 >> 2);
  localparam logic [WI-1:0] W_DOUT   = WI'('h0C >> 2);
  localparam logic [WI-1:0] W_OE     = WI'('h10 >> 2);
  localparam logic [WI-1:0] W_ODR    = WI'('h14 >> 2);
  localparam logic [WI-1:0] W_PU     = WI'('h18 >> 2);
  localparam logic [WI-1:0] W_PD     = WI'('h1C >> 2);
  localparam logic [WI-1:0] W_INEN   = WI'('h20 >> 2);
  localparam logic [WI-1:0] W_EVTY   = WI'('h24 >> 2);
  localparam logic [WI-1:0] W_EVBO   = WI'('h28 >> 2);
  localparam logic [WI-1:0] W_EVEN   = WI'('h2C >> 2);
  localparam logic [WI-1:0] W_EVSET  = WI'('h30 >> 2);
  localparam logic [WI-1:0] W_EVCLR  = WI'('h34 >> 2);
  localparam logic [WI-1:0] W_SLEW   = WI'('h38 >> 2);
  localparam logic [WI-1:0] W_DRV    = WI'('h3C >> 2);
  localparam logic [WI-1:0] W_DOSET  = WI'('h68 >> 2);
  localparam logic [WI-1:0] W_DOCLR  = WI'('h6C >> 2);
  localparam logic [WI-1:0] W_OESET  = WI'('h70 >> 2);
  localparam logic [WI-1:0] W_OECLR  = WI'('h74 >> 2);
  localparam logic [WI-1:0] W_LOCKB  = WI'('h7C >> 2);

  logic          locked, lock_b_hit;
  logic [31:0]   lock_b;
  logic [WI-1:0] word;
  logic          aligned, mapped, is_lock, wr, rd_hit;
  logic [31:0]   rd_val;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = bus_addr[1:0] == 2'b00;
  assign is_lock = (word == W_LOCKA) || (word == W_LOCKB);
  assign wr      = bus_valid && bus_write && aligned;
  assign lock_b_hit = lock_b == KEY_B;

  always_comb begin
    rd_hit = 1'b1;
    rd_val = 32'h0;
    case (word)
      W_LOCKA: rd_val = {31'h0, locked};
      W_PIN:   rd_val = pin_in;
      W_POL:   rd_val = pol_o;
      W_DOUT:  rd_val = dout_o;
      W_OE:    rd_val = oe_o;
      W_ODR:   rd_val = odrain_o;
      W_PU:    rd_val = pull_up_o;
      W_PD:    rd_val = pull_dn_o;
      W_INEN:  rd_val = in_en_o;
      W_EVTY:  rd_val = ev_type_o;
      W_EVBO:  rd_val = ev_both_o;
      W_EVEN:  rd_val = ev_en_o;
      W_SLEW:  rd_val = slew_o;
      W_DRV:   rd_val = drive_o;
      W_EVSET, W_EVCLR, W_DOSET, W_DOCLR, W_OESET, W_OECLR, W_LOCKB: rd_val = 32'h0;
      default: rd_hit = 1'b0;
    endcase
    mapped = rd_hit && aligned;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;  lock_b <= '0;
      pol_o <= '0;  dout_o <= '0;  oe_o <= '0;  odrain_o <= '0;
      in_en_o <= '0;  ev_type_o <= '0;  ev_both_o <= '0;  ev_en_o <= '0;
      pull_up_o <= PU_RST;  pull_dn_o <= PD_RST;
      slew_o <= SLEW_RST;   drive_o <= DRIVE_RST;
      bus_rdata <= '0;  bus_err <= 1'b0;
    end else begin
      bus_err <= bus_valid && (!mapped || (bus_write && locked && !is_lock));
      if (bus_valid && !bus_write) bus_rdata <= mapped ? rd_val : 32'h0;
      if (wr && locked) begin
        if (word == W_LOCKB) lock_b <= bus_wdata;
        else if (word == W_LOCKA && bus_wdata == KEY_A && lock_b_hit) begin
          locked <= 1'b0;
          lock_b <= '0;
        end
      end else if (wr) begin
        case (word)
          W_LOCKA, W_LOCKB: begin locked <= 1'b1; lock_b <= '0; end
          W_POL:   pol_o     <= bus_wdata;
          W_DOUT:  dout_o    <= bus_wdata;
          W_OE:    oe_o      <= bus_wdata;
          W_ODR:   odrain_o  <= bus_wdata;
          W_PU:    pull_up_o <= bus_wdata;
          W_PD:    pull_dn_o <= bus_wdata;
          W_INEN:  in_en_o   <= bus_wdata;
          W_EVTY:  ev_type_o <= bus_wdata;
          W_EVBO:  ev_both_o <= bus_wdata;
          W_EVEN:  ev_en_o   <= bus_wdata;
          W_EVSET: ev_en_o   <= ev_en_o | bus_wdata;
          W_EVCLR: ev_en_o   <= ev_en_o & ~bus_wdata;
          W_SLEW:  slew_o    <= bus_wdata;
          W_DRV:   drive_o   <= bus_wdata;
          W_DOSET: dout_o    <= dout_o | bus_wdata;
          W_DOCLR: dout_o    <= dout_o & ~bus_wdata;
          W_OESET: oe_o      <= oe_o | bus_wdata;
          W_OECLR: oe_o      <= oe_o & ~bus_wdata;
          default: ;
        endcase
      end
    end
  end

  p_engage_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !locked && is_lock) |=> (locked && lock_b == 32'h0));

  p_locked_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && locked && mapped && !is_lock) |=>
      (bus_err && $stable(dout_o) && $stable(oe_o) && $stable(pol_o) && $stable(ev_en_o)));

  p_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && locked && word == W_LOCKA && bus_wdata == KEY_A && lock_b == KEY_B) |=>
      (!locked && lock_b == 32'h0));

  p_wrong_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && locked && word == W_LOCKA && (bus_wdata != KEY_A || lock_b != KEY_B)) |=>
      (locked && !bus_err));

  p_bad_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !aligned) |=> (bus_err && $stable(dout_o) && $stable(oe_o)));

  p_wo_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && aligned && word == W_LOCKB) |=> bus_rdata == 32'h0);

  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !bus_err);
endmodule

// File: tb/gpio_lock_regs_tb.sv
module gpio_lock_regs_tb;
  localparam logic [31:0] PU = 32'h0000_00F0, PD = 32'h0F00_0000;
  localparam logic [31:0] SL = 32'h1234_0000, DR = 32'h0000_8001;
  localparam logic [31:0] PIN = 32'h5A5A_C3C3;
  localparam int NV = 26;
  // {write, addr[11:0], wdata, expected rdata, expected err}
  localparam logic [77:0] VEC [NV] = '{
    {1'b1, 12'h00C, 32'hAAAA_0000, 32'h0, 1'b0},
    {1'b0, 12'h00C, 32'h0, 32'hAAAA_0000, 1'b0},
    {1'b1, 12'h068, 32'h0000_00FF, 32'h0, 1'b0},          // R6
    {1'b0, 12'h00C, 32'h0, 32'hAAAA_00FF, 1'b0},          // R6
    {1'b1, 12'h06C, 32'hA000_000F, 32'h0, 1'b0},          // R6
    {1'b0, 12'h00C, 32'h0, 32'h0AAA_00F0, 1'b0},          // R6
    {1'b1, 12'h070, 32'h0000_FF00, 32'h0, 1'b0},          // R6
    {1'b0, 12'h010, 32'h0, 32'h0000_FF00, 1'b0},          // R6
    {1'b1, 12'h074, 32'h0000_0F00, 32'h0, 1'b0},          // R6
    {1'b0, 12'h010, 32'h0, 32'h0000_F000, 1'b0},          // R6
    {1'b0, 12'h068, 32'h0, 32'h0, 1'b0},                  // R7
    {1'b0, 12'h074, 32'h0, 32'h0, 1'b0},                  // R7
    {1'b1, 12'h02C, 32'h0000_0011, 32'h0, 1'b0},          // R12
    {1'b1, 12'h030, 32'h0000_0100, 32'h0, 1'b0},          // R12
    {1'b1, 12'h034, 32'h0000_0001, 32'h0, 1'b0},          // R12
    {1'b0, 12'h02C, 32'h0, 32'h0000_0110, 1'b0},          // R12
    {1'b0, 12'h030, 32'h0, 32'h0, 1'b0},                  // R7
    {1'b1, 12'h004, 32'hFFFF_FFFF, 32'h0, 1'b0},          // R8
    {1'b0, 12'h004, 32'h0, PIN, 1'b0},                    // R8
    {1'b0, 12'h002, 32'h0, 32'h0, 1'b1},                  // R9
    {1'b1, 12'h080, 32'h0000_0123, 32'h0, 1'b1},          // R9
    {1'b0, 12'h080, 32'h0, 32'h0, 1'b1},                  // R9
    {1'b1, 12'h00E, 32'h0000_0001, 32'h0, 1'b1},          // R9
    {1'b0, 12'h00C, 32'h0, 32'h0AAA_00F0, 1'b0},          // R9
    {1'b1, 12'h008, 32'h00FF_00FF, 32'h0, 1'b0},
    {1'b0, 12'h008, 32'h0, 32'h00FF_00FF, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = PIN;
  logic [31:0] bus_rdata, pol_o, dout_o, oe_o, odrain_o, pull_up_o, pull_dn_o;
  logic [31:0] in_en_o, ev_type_o, ev_both_o, ev_en_o, slew_o, drive_o;
  logic bus_err;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  gpio_lock_regs #(.ADDR_W(12), .PU_RST(PU), .PD_RST(PD), .SLEW_RST(SL), .DRIVE_RST(DR)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .pin_in(pin_in), .pol_o(pol_o), .dout_o(dout_o), .oe_o(oe_o), .odrain_o(odrain_o),
    .pull_up_o(pull_up_o), .pull_dn_o(pull_dn_o), .in_en_o(in_en_o),
    .ev_type_o(ev_type_o), .ev_both_o(ev_both_o), .ev_en_o(ev_en_o),
    .slew_o(slew_o), .drive_o(drive_o));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    acc(1'b0, a, 32'h0);
    chk(req, bus_rdata, exp);
  endtask

  task automatic wr_chk(input string req, input logic [11:0] a, input logic [31:0] d, input logic e);
    acc(1'b1, a, d);
    chk(req, {31'h0, bus_err}, {31'h0, e});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 pull-up", 12'h018, PU);
    rd_chk("R1 pull-down", 12'h01C, PD);
    rd_chk("R1 slew", 12'h038, SL);
    rd_chk("R1 drive", 12'h03C, DR);
    rd_chk("R1 lock word A", 12'h000, 32'h0);
    rd_chk("R1 data out", 12'h00C, 32'h0);
    chk("R1 drive port", drive_o, DR);
    chk("R1 oe port", oe_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][77], VEC[i][76:65], VEC[i][64:33]);
      if (!VEC[i][77]) chk($sformatf("R11 vector %0d rdata", i), bus_rdata, VEC[i][32:1]);
      chk($sformatf("R9 vector %0d err", i), {31'h0, bus_err}, {31'h0, VEC[i][0]});
    end
    @(negedge clk);
    chk("R11 error lasts one cycle", {31'h0, bus_err}, 32'h0);
    chk("R6 dout port", dout_o, 32'h0AAA_00F0);

    // lock sequences
    wr_chk("R2 engage via B", 12'h07C, 32'h1234_5678, 1'b0);
    rd_chk("R2 locked reads 1", 12'h000, 32'h1);
    wr_chk("R3 dropped write err", 12'h00C, 32'h0, 1'b1);
    rd_chk("R3 R10 dout kept", 12'h00C, 32'h0AAA_00F0);
    wr_chk("R3 alias dropped err", 12'h068, 32'hFFFF_FFFF, 1'b1);
    chk("R3 dout port kept", dout_o, 32'h0AAA_00F0);
    wr_chk("R5 key A without key B", 12'h000, 32'hC0DE_FA73, 1'b0);
    rd_chk("R5 still locked", 12'h000, 32'h1);
    wr_chk("R4 store key B", 12'h07C, 32'hC0DE_1248, 1'b0);
    rd_chk("R7 lock word B reads zero", 12'h07C, 32'h0);
    wr_chk("R5 wrong key A", 12'h000, 32'h0000_1234, 1'b0);
    rd_chk("R5 still locked 2", 12'h000, 32'h1);
    wr_chk("R4 unlock", 12'h000, 32'hC0DE_FA73, 1'b0);
    rd_chk("R4 unlocked", 12'h000, 32'h0);
    wr_chk("R4 write after unlock", 12'h00C, 32'h0000_0001, 1'b0);
    rd_chk("R4 dout written", 12'h00C, 32'h1);
    wr_chk("R2 engage via A", 12'h000, 32'h0, 1'b0);
    wr_chk("R4 B cleared so no unlock", 12'h000, 32'hC0DE_FA73, 1'b0);
    rd_chk("R4 relocked holds", 12'h000, 32'h1);
    rd_chk("R10 read pull-up while locked", 12'h018, PU);
    rd_chk("R9 unmapped read locked", 12'h0F0, 32'h0);
    chk("R9 unmapped err", {31'h0, bus_err}, 32'h1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule